// File: doc/BRIEF.md
# Frame-Aligned Transmit Elastic Store

This block sits between the system side and the line side of a T1 transmitter. It holds serial bits that arrive on the system side and hands them to the line side, so that small rate differences and wander between the two bit streams are absorbed. Both sides run in one core clock domain. Each side is paced by a one-cycle bit strobe, and a frame marker is raised with the first bit of every frame.

The depth is chosen at run time in whole frames. The choices are no buffering (bypass), one frame, or two frames. A pulse on the offset input, or any change of the size control, flushes the store and puts the read and write positions half the selected depth apart.

When the store runs full or empty, the block treats the event as a frame slip. It moves the read position by one whole frame, so that one frame is dropped or one frame is repeated. The bit alignment within frames is kept. Each kind of slip sets its own sticky status bit, and an interrupt is raised while any unmasked status bit is set.

Top module: `tx_elastic_store`

## Requirements
- R1: With size control 00 (bypass), each cycle with `line_bit_en` high loads `sys_data` into `line_data`, visible one cycle later; nothing is stored.
- R2: Size control 01 gives an active depth of FRAME_BITS bits. Size control 10 or 11 gives FRAME_BITS*MAX_FRAMES bits. After a re-centre, exactly depth minus floor(depth/2) writes without reads fill the store, and the next such write is an overflow.
- R3: After a re-centre, the system side accepts its first bit only when `sys_frame` is high. The line side consumes its first bit only when `line_frame` is high. Strobes that come before these are ignored.
- R4: Outside bypass, the bits leave in the order they were accepted, preceded by floor(depth/2) zero bits after a re-centre. `line_data` shows the bit one cycle after its read strobe.
- R5: An accepted write into a full store, with no read in the same cycle, is an overflow slip. The read position advances by one frame, dropping FRAME_BITS unread bits, and status bit 0 is set.
- R6: An accepted read from an empty store, with no write in the same cycle, is an underflow slip. The read position moves back by one frame, so the last FRAME_BITS bits are read again, and status bit 1 is set.
- R7: `slip_status` bits are sticky: bit 0 records overflow and bit 1 records underflow. A cycle with `status_rd` high clears them. A slip in that same cycle wins over the clear.
- R8: `irq` is high while any `slip_status` bit is set whose `irq_mask` bit is 0. A mask bit of 1 suppresses that bit.
- R9: A pulse on `offset_wr`, a change of `size_sel`, or the first cycle after reset flushes the store. The contents are zeroed, the fill becomes floor(depth/2), strobes in that cycle are ignored, and `line_data` becomes 0.
- R10: In bypass, no slip is detected and `slip_status` is not set.
- R11: An accepted read and write in the same cycle never cause a slip. When the store is empty, the bit written in that cycle is passed straight to `line_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_bit_en | input | 1 | System-side bit strobe |
| sys_frame | input | 1 | System-side frame-start marker, qualified by `sys_bit_en` |
| sys_data | input | 1 | System-side data bit |
| line_bit_en | input | 1 | Line-side bit strobe |
| line_frame | input | 1 | Line-side frame-start marker, qualified by `line_bit_en` |
| line_data | output | 1 | Line-side data bit, registered |
| size_sel | input | 2 | Depth select: 00 bypass, 01 one frame, 10/11 two frames |
| offset_wr | input | 1 | Re-centre pulse, sent when the transmit offset is programmed |
| status_rd | input | 1 | Status read strobe; clears the sticky slip bits |
| irq_mask | input | 2 | Per-bit interrupt mask, 1 = masked |
| slip_status | output | 2 | Sticky slip bits: bit 0 overflow, bit 1 underflow |
| irq | output | 1 | Interrupt, high while any unmasked status bit is set |

## Verification
The bench uses a small frame size and sweeps every buffered depth with four strobe patterns:
- Equal rates test plain ordering.
- A faster writer forces overflow, which tells a dropped frame apart from a dropped bit.
- A faster reader forces underflow, which shows that a whole frame is repeated.
- Mismatched 2:3 cadences mix accepted reads, writes and idles in every phase.

Directed runs cover the rest:
- Fill-to-overflow counts at each size code, which separate one-frame depth from two-frame depth and show that codes 10 and 11 behave alike.
- Strobes that come before the frame markers, to show they are ignored.
- Simultaneous read and write at an empty store, to show the forwarding path.
- Unbalanced traffic in bypass, which must leave the status untouched.

// File: rtl/tx_es_pkg.sv
package tx_es_pkg;

  typedef enum logic [1:0] {
    SZ_BYPASS  = 2'b00,
    SZ_ONE     = 2'b01,
    SZ_TWO     = 2'b10,
    SZ_TWO_ALT = 2'b11
  } size_e;

  // Active depth in bits for a size code (0 means bypass).
  function automatic int active_depth(input logic [1:0] sz, input int fbits, input int frames);
    case (sz)
      SZ_BYPASS: return 0;
      SZ_ONE:    return fbits;
      default:   return fbits * frames;
    endcase
  endfunction

  // Modular add/subtract on a ring of d entries; p < d and k <= d.
  function automatic int ring_add(input int p, input int k, input int d);
    int s;
    s = p + k;
    return (s >= d) ? s - d : s;
  endfunction

  function automatic int ring_sub(input int p, input int k, input int d);
    return (p >= k) ? p - k : p + d - k;
  endfunction

endpackage

// File: rtl/tx_es_store.sv
module tx_es_store #(
  parameter int DEPTH = 386,
  parameter int PW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic          wdata,
  input  logic [PW-1:0] raddr,
  output logic          rdata
);
  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cells <= '0;
    else if (flush)  cells <= '0;
    else if (we)     cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/tx_es_ctrl.sv
module tx_es_ctrl
  import tx_es_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int PW         = 9,
  parameter int CW         = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          bypass,
  input  logic [CW-1:0] depth,
  input  logic          wr_stb,
  input  logic          wr_frm,
  input  logic          rd_stb,
  input  logic          rd_frm,
  output logic          wr_en,
  output logic          rd_en,
  output logic          fwd,
  output logic          ovf_evt,
  output logic          udf_evt,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_addr,
  output logic [CW-1:0] fill
);
  logic [PW-1:0] rd_ptr;
  logic          wr_go, rd_go;
  logic [CW-1:0] fill_nx;
  int            d_i, f_i;

  always_comb begin
    d_i     = int'(32'(depth));
    f_i     = int'(32'(fill));
    wr_en   = !flush && !bypass && wr_stb && (wr_go || wr_frm);
    rd_en   = !flush && !bypass && rd_stb && (rd_go || rd_frm);
    ovf_evt = wr_en && !rd_en && (fill == depth);
    udf_evt = rd_en && !wr_en && (fill == '0);
    fwd     = wr_en && rd_en && (fill == '0);
    if (ovf_evt)
      rd_addr = PW'(ring_add(int'(32'(rd_ptr)), FRAME_BITS, d_i));
    else if (udf_evt)
      rd_addr = PW'(ring_sub(int'(32'(rd_ptr)), FRAME_BITS, d_i));
    else
      rd_addr = rd_ptr;
    fill_nx = CW'(f_i + (wr_en ? 1 : 0) - (rd_en ? 1 : 0)
                  + (udf_evt ? FRAME_BITS : 0) - (ovf_evt ? FRAME_BITS : 0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      wr_go  <= 1'b0;
      rd_go  <= 1'b0;
    end else if (flush) begin
      wr_ptr <= PW'(depth >> 1);
      rd_ptr <= '0;
      fill   <= depth >> 1;
      wr_go  <= 1'b0;
      rd_go  <= 1'b0;
    end else begin
      if (wr_en) begin
        wr_go  <= 1'b1;
        wr_ptr <= PW'(ring_add(int'(32'(wr_ptr)), 1, d_i));
      end
      if (rd_en) begin
        rd_go  <= 1'b1;
        rd_ptr <= PW'(ring_add(int'(32'(rd_addr)), 1, d_i));
      end else if (ovf_evt) begin
        rd_ptr <= rd_addr;
      end
      if (wr_en || rd_en) fill <= fill_nx;
    end
  end
endmodule

// File: rtl/tx_es_irq.sv
module tx_es_irq #(
  parameter int NEV = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set_ev,
  input  logic           clr,
  input  logic [NEV-1:0] mask,
  output logic [NEV-1:0] status,
  output logic           irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~{NEV{clr}}) | set_ev;
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/tx_elastic_store.sv
module tx_elastic_store
  import tx_es_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int MAX_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_bit_en,
  input  logic       sys_frame,
  input  logic       sys_data,
  input  logic       line_bit_en,
  input  logic       line_frame,
  output logic       line_data,
  input  logic [1:0] size_sel,
  input  logic       offset_wr,
  input  logic       status_rd,
  input  logic [1:0] irq_mask,
  output logic [1:0] slip_status,
  output logic       irq
);
  localparam int DEPTH = FRAME_BITS * MAX_FRAMES;
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [1:0]    size_q;
  logic          primed;
  logic          flush, bypass;
  logic [CW-1:0] depth;
  logic          wr_en, rd_en, fwd, ovf_evt, udf_evt;
  logic [PW-1:0] wr_ptr, rd_addr;
  logic [CW-1:0] fill;
  logic          rdata;

  assign bypass = (size_sel == SZ_BYPASS);
  assign depth  = CW'(active_depth(size_sel, FRAME_BITS, MAX_FRAMES));
  assign flush  = offset_wr || !primed || (size_q != size_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_BYPASS;
      primed <= 1'b0;
    end else begin
      size_q <= size_sel;
      primed <= 1'b1;
    end
  end

  tx_es_ctrl #(.FRAME_BITS(FRAME_BITS), .PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .bypass(bypass), .depth(depth),
    .wr_stb(sys_bit_en), .wr_frm(sys_frame), .rd_stb(line_bit_en), .rd_frm(line_frame),
    .wr_en(wr_en), .rd_en(rd_en), .fwd(fwd), .ovf_evt(ovf_evt), .udf_evt(udf_evt),
    .wr_ptr(wr_ptr), .rd_addr(rd_addr), .fill(fill)
  );

  tx_es_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .we(wr_en), .waddr(wr_ptr),
    .wdata(sys_data), .raddr(rd_addr), .rdata(rdata)
  );

  tx_es_irq #(.NEV(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev({udf_evt, ovf_evt}), .clr(status_rd),
    .mask(irq_mask), .status(slip_status), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      line_data <= 1'b0;
    else if (flush)                  line_data <= 1'b0;
    else if (bypass && line_bit_en)  line_data <= sys_data;
    else if (rd_en)                  line_data <= fwd ? sys_data : rdata;
  end
endmodule

// File: rtl/tx_elastic_store_chk.sv
module tx_elastic_store_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          bypass,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ovf_evt,
  input logic          udf_evt,
  input logic [CW-1:0] fill,
  input logic [CW-1:0] depth,
  input logic          status_rd,
  input logic [1:0]    slip_status,
  input logic          irq
);
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !flush) |-> (fill <= depth));

  a_r9_recentre: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == ($past(depth) >> 1)));

  a_r4_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !udf_evt) |=> (fill == $past(fill) - 1'b1));

  a_r5_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> slip_status[0]);

  a_r6_udf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> slip_status[1]);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ovf_evt && !udf_evt) |=> (slip_status == 2'b00));

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_status == 2'b00) |-> !irq);

  a_r10_bypass_no_slip: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (!ovf_evt && !udf_evt));
endmodule

bind tx_elastic_store tx_elastic_store_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .bypass(bypass), .wr_en(wr_en),
  .rd_en(rd_en), .ovf_evt(ovf_evt), .udf_evt(udf_evt), .fill(fill), .depth(depth),
  .status_rd(status_rd), .slip_status(slip_status), .irq(irq)
);

// File: tb/tx_elastic_store_tb.sv
`timescale 1ns/1ps
module tx_elastic_store_tb;
  localparam int F  = 5;
  localparam int MF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_bit_en = 0, sys_frame = 0, sys_data = 0;
  logic line_bit_en = 0, line_frame = 0;
  logic [1:0] size_sel = 2'b10, irq_mask = 2'b00;
  logic offset_wr = 0, status_rd = 0;
  logic line_data, irq;
  logic [1:0] slip_status;

  always #2 clk = ~clk;

  tx_elastic_store #(.FRAME_BITS(F), .MAX_FRAMES(MF)) u_dut (
    .clk(clk), .rst_n(rst_n), .sys_bit_en(sys_bit_en), .sys_frame(sys_frame),
    .sys_data(sys_data), .line_bit_en(line_bit_en), .line_frame(line_frame),
    .line_data(line_data), .size_sel(size_sel), .offset_wr(offset_wr),
    .status_rd(status_rd), .irq_mask(irq_mask), .slip_status(slip_status), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  string tag = "R4";

  // Reference model: absolute slot numbers, slot s lives in a history array.
  bit   hist [0:2047];
  int   m_w, m_r, m_d, m_half;
  bit   m_wgo, m_rgo, m_primed = 0;
  logic [1:0] m_prev = 2'b00, m_stat = 2'b00;
  logic m_line = 0;

  function automatic int depth_of(input logic [1:0] s);
    if (s == 2'b00) return 0;
    if (s == 2'b01) return F;
    return 2 * F;
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic step(input logic se, input logic sf, input logic sd,
                      input logic le, input logic lf, input logic srd, input logic ofs);
    bit flush, wr, rd, ov, ud;
    int fill;
    @(negedge clk);
    sys_bit_en = se; sys_frame = sf; sys_data = sd;
    line_bit_en = le; line_frame = lf; status_rd = srd; offset_wr = ofs;
    @(posedge clk);
    #1;
    ov = 0; ud = 0;
    flush = ofs || !m_primed || (size_sel != m_prev);
    m_primed = 1; m_prev = size_sel;
    if (flush) begin
      m_d = depth_of(size_sel); m_half = m_d / 2;
      for (int i = 0; i < 2048; i++) hist[i] = 0;
      m_w = m_half; m_r = 0; m_wgo = 0; m_rgo = 0; m_line = 0;
      chk("R9 flush line", 32'(line_data), 32'(m_line));
    end else if (size_sel == 2'b00) begin
      if (le) begin
        m_line = sd;
        chk("R1 bypass line", 32'(line_data), 32'(m_line));
      end
    end else begin
      wr = se && (m_wgo || sf);
      rd = le && (m_rgo || lf);
      if (wr) m_wgo = 1;
      if (rd) m_rgo = 1;
      fill = m_w - m_r;
      ov = wr && !rd && (fill == m_d);
      ud = rd && !wr && (fill == 0);
      if (ov) m_r += F;
      if (ud) m_r -= F;
      if (rd) begin
        if (wr && fill == 0) m_line = sd;
        else m_line = (m_r < 0) ? 1'b0 : hist[m_r];
        m_r++;
      end
      if (wr) begin hist[m_w] = sd; m_w++; end
      if (rd) chk({tag, " line"}, 32'(line_data), 32'(m_line));
    end
    m_stat = (m_stat & ~{2{srd}}) | {ud, ov};
    chk("R7 status", 32'(slip_status), 32'(m_stat));
    chk("R8 irq", 32'(irq), 32'(|(m_stat & ~irq_mask)));
  endtask

  task automatic idle_clear();
    step(0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int wn, rn;
    logic se, le, sd;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset line", 32'(line_data), 32'd0);
    chk("R7 reset status", 32'(slip_status), 32'd0);
    chk("R8 reset irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);

    // Sweep: buffered sizes x strobe patterns.
    for (int s = 1; s <= 3; s++) begin
      for (int p = 0; p < 4; p++) begin
        size_sel = 2'(s);
        irq_mask = (s == 2) ? 2'b01 : 2'b00;
        tag = (p == 1) ? "R5" : (p == 2) ? "R6" : "R4";
        step(0, 0, 0, 0, 0, 1, 1);
        wn = 0; rn = 0;
        for (int c = 0; c < 200; c++) begin
          case (p)
            0: begin se = 1; le = 1; end
            1: begin se = 1; le = (c % 5) != 4; end
            2: begin se = (c % 5) != 4; le = 1; end
            default: begin se = (c % 2) == 0; le = (c % 3) == 1; end
          endcase
          sd = 1'((c * 7) ^ (c >> 2) ^ s);
          step(se, se && (wn % F == 0), sd, le, le && (rn % F == 0), 0, 0);
          if (se) wn++;
          if (le) rn++;
        end
        if (p == 1) chk("R5 overflow flagged", 32'(slip_status[0]), 32'd1);
        if (p == 2) chk("R6 underflow flagged", 32'(slip_status[1]), 32'd1);
        idle_clear();
      end
    end
    irq_mask = 2'b00;

    // R2: writes to overflow per size code.
    for (int s = 1; s <= 3; s++) begin
      int d;
      size_sel = 2'(s);
      d = depth_of(2'(s));
      step(0, 0, 0, 0, 0, 1, 1);
      for (int k = 0; k < d - d / 2; k++) step(1, k == 0, 1, 0, 0, 0, 0);
      chk("R2 full without slip", 32'(slip_status), 32'd0);
      step(1, 0, 1, 0, 0, 0, 0);
      chk("R2 overflow at depth", 32'(slip_status), 32'd1);
      idle_clear();
    end

    // R3: strobes before markers are ignored.
    tag = "R3";
    size_sel = 2'b10;
    step(0, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 3; k++) step(1, 0, 1, 1, 0, 0, 0);
    for (int k = 0; k < 12; k++) step(1, k == 0, 1'(k & 1), 1, k == 0, 0, 0);
    chk("R3 no slip", 32'(slip_status), 32'd0);

    // R11: simultaneous read and write at empty store forwards input.
    tag = "R11";
    size_sel = 2'b01;
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < 10; k++) step(1, k == 0, 1'(~k & 1), 1, 0, 0, 0);
    chk("R11 no slip", 32'(slip_status), 32'd0);

    // R10 / R1: bypass with unbalanced strobes.
    size_sel = 2'b00;
    idle_clear();
    for (int k = 0; k < 40; k++) step(1, 0, 1'((k * 3) >> 1), (k % 3) == 0, 0, 0, 0);
    chk("R10 bypass status", 32'(slip_status), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule